// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one synchronous DRAM burst, one per clock. A column command pulse loads the starting column together with the programmed burst length and burst ordering, and from the next cycle the block emits beat 0, beat 1 and so on, marking the final beat of a fixed-length burst. A full-page burst walks every column of the row and keeps going until it is stopped or replaced. The controller that owns the bank uses the address stream to drive the column bus. It stops a burst with the stop input, or issues a new column command, which restarts the sequence at once.

The controller has three states. `ST_IDLE` emits nothing. `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats. `ST_PAGE` runs an open-ended full-page burst. The transitions are: start-fixed (any state to `ST_FIXED` on a legal fixed-length command), start-page (any state to `ST_PAGE` on a legal full-page command), reject (any state to `ST_IDLE` on a reserved configuration), halt (`ST_FIXED` or `ST_PAGE` to `ST_IDLE` on stop), drain (`ST_FIXED` to `ST_IDLE` after its last beat) and hold (every other case keeps the state). A column command takes priority over stop in the same cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and in the cycle after reset is released, col_valid, last_beat and cfg_err are low.
- R2: A legal column command on cmd_start makes col_valid high in the next cycle with col_out equal to cmd_col. Each following cycle of the burst carries the next beat.
- R3: len_sel selects the burst length: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives a full page. A fixed burst of N beats keeps col_valid high for exactly N cycles.
- R4: With ilv_mode low, beat i of an N-beat fixed burst is the start column with its low log2(N) bits replaced by (start + i) mod N. The upper bits are kept.
- R5: With ilv_mode high, beat i of an N-beat fixed burst is the start column with its low log2(N) bits XORed with i.
- R6: A full-page burst steps (start + i) mod 256. It never raises last_beat and keeps running until stop or a new column command.
- R7: last_beat is high on the final beat of a fixed burst only. In the next cycle col_valid is low unless a new command was taken.
- R8: A command with len_sel 3'b100, 3'b101 or 3'b110, or with full page while ilv_mode is high, raises cfg_err for exactly the next cycle. It produces no beats and ends any burst in progress.
- R9: burst_stop without cmd_start drops col_valid in the next cycle, and it stays low.
- R10: A column command during a burst discards the old burst, and the next cycle shows beat 0 of the new one. When cmd_start and burst_stop come together, the command wins.
- R11: With wr_single high, a write command (cmd_write high) runs a single beat whatever len_sel programs. Reads keep the programmed length. The reserved-configuration check of R8 still applies to the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Column command pulse (read or write) |
| cmd_write | input | 1 | High when the command is a write |
| cmd_col | input | 8 | Starting column of the command |
| burst_stop | input | 1 | Ends the running burst |
| len_sel | input | 3 | Programmed burst length code |
| ilv_mode | input | 1 | 1 = interleaved ordering, 0 = sequential |
| wr_single | input | 1 | Writes run a single beat |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | col_out carries a beat |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |
| cfg_err | output | 1 | Previous command used a reserved configuration |

## Verification
The bench starts bursts at columns that are not aligned to the burst length, such as 5 and 6, in both orderings. A design that carried into the upper bits, or that swapped XOR for addition, would leave the aligned block or produce the wrong beat order. A full-page burst starts at 250 and is driven well past 256 beats, which catches a wrap into column 256 and a stray last_beat. Restarts land on the last beat, in mid-burst and together with stop, so that a wrong priority or a beat counter that is not cleared shows up as a stale or missing beat. Reserved codes are issued during a live burst, and single-beat writes are mixed with reads, to expose a burst that survives an error or a forced length that leaks onto reads.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_sel,
    input  logic             ilv,
    input  logic             is_write,
    input  logic             wr_single,
    output logic [COL_W-1:0] mask,
    output logic             page,
    output logic             err
);
    import bcg_pkg::*;

    localparam logic [COL_W-1:0] MASK_1 = '0;
    localparam logic [COL_W-1:0] MASK_2 = COL_W'(1);
    localparam logic [COL_W-1:0] MASK_4 = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_8 = COL_W'(7);

    logic [COL_W-1:0] prog_mask;
    logic             prog_page;

    always_comb begin
        prog_mask = MASK_1;
        prog_page = 1'b0;
        err       = 1'b0;
        unique case (len_sel)
            LEN_ONE:   prog_mask = MASK_1;
            LEN_TWO:   prog_mask = MASK_2;
            LEN_FOUR:  prog_mask = MASK_4;
            LEN_EIGHT: prog_mask = MASK_8;
            LEN_PAGE: begin
                prog_mask = '1;
                prog_page = 1'b1;
                err       = ilv;
            end
            default:   err = 1'b1;
        endcase
    end

    always_comb begin
        if (is_write && wr_single) begin
            mask = MASK_1;
            page = 1'b0;
        end else begin
            mask = prog_mask;
            page = prog_page;
        end
    end

endmodule

// File: rtl/bcg_addr_gen.sv
module bcg_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] seq_addr;
    logic [COL_W-1:0] ilv_addr;

    assign seq_sum = base + beat;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign seq_addr[b] = mask[b] ? seq_sum[b] : base[b];
        assign ilv_addr[b] = base[b] ^ (beat[b] & mask[b]);
    end

    assign addr = ilv ? ilv_addr : seq_addr;

    // R4: sequential beats advance by one inside the masked field
    assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ilv && beat != '0) |->
        ((addr & mask) == (($past(addr) + 1'b1) & mask)));

    // R5: interleaved beats flip exactly the bits that the count flips
    assert_ilv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ilv && beat != '0) |->
        ((addr ^ $past(addr)) == ((beat ^ (beat - 1'b1)) & mask)));

endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             ilv_in,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_page,
    input  logic             dec_err,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] beat_q,
    output logic [COL_W-1:0] mask_q,
    output logic             ilv_q,
    output logic             col_valid,
    output logic             last_beat,
    output logic             cfg_err
);
    import bcg_pkg::*;

    bcg_state_e state_q, state_d;
    logic       err_q;
    logic       at_end;
    logic       take_cmd;

    assign at_end   = (beat_q == mask_q);
    assign take_cmd = cmd_start && !dec_err;

    always_comb begin
        state_d = state_q;
        if (cmd_start) begin
            if (dec_err)       state_d = ST_IDLE;
            else if (dec_page) state_d = ST_PAGE;
            else               state_d = ST_FIXED;
        end else if (burst_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_FIXED: state_d = at_end ? ST_IDLE : ST_FIXED;
                ST_PAGE:  state_d = ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= cmd_start && dec_err;
            if (take_cmd) begin
                base_q <= cmd_col;
                beat_q <= '0;
                mask_q <= dec_mask;
                ilv_q  <= ilv_in;
            end else if (state_q != ST_IDLE) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        col_valid = 1'b0;
        last_beat = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_FIXED: begin
                col_valid = 1'b1;
                last_beat = at_end;
            end
            ST_PAGE:  col_valid = 1'b1;
            default:  ;
        endcase
    end

    assign cfg_err = err_q;

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!col_valid && !cfg_err && !last_beat));

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_cmd |=> (col_valid && beat_q == '0 && base_q == $past(cmd_col)));

    assert_fixed_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXED) |-> (beat_q <= mask_q));

    assert_page_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE) |-> !last_beat);

    assert_last_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_start) |=> !col_valid);

    assert_err_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !col_valid);

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !cmd_start) |=> !col_valid);

    assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && burst_stop) |=> col_valid);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             burst_stop,
    input  logic [2:0]       len_sel,
    input  logic             ilv_mode,
    input  logic             wr_single,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat,
    output logic             cfg_err
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_err;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic             ilv_q;

    bcg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_sel   (len_sel),
        .ilv       (ilv_mode),
        .is_write  (cmd_write),
        .wr_single (wr_single),
        .mask      (dec_mask),
        .page      (dec_page),
        .err       (dec_err)
    );

    bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .burst_stop (burst_stop),
        .cmd_col    (cmd_col),
        .ilv_in     (ilv_mode),
        .dec_mask   (dec_mask),
        .dec_page   (dec_page),
        .dec_err    (dec_err),
        .base_q     (base_q),
        .beat_q     (beat_q),
        .mask_q     (mask_q),
        .ilv_q      (ilv_q),
        .col_valid  (col_valid),
        .last_beat  (last_beat),
        .cfg_err    (cfg_err)
    );

    bcg_addr_gen #(.COL_W(COL_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (col_valid),
        .base  (base_q),
        .beat  (beat_q),
        .mask  (mask_q),
        .ilv   (ilv_q),
        .addr  (col_out)
    );

    // R11: a single-beat write ends on its first beat
    assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && cmd_write && wr_single && !dec_err) |=> last_beat);

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = '0;
    logic       burst_stop = 1'b0;
    logic [2:0] len_sel = '0;
    logic       ilv_mode = 1'b0;
    logic       wr_single = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       last_beat;
    logic       cfg_err;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_act = 0, m_page = 0, m_base = 0, m_beat = 0, m_len = 1, m_ilv = 0, m_err = 0;

    always #5 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .burst_stop(burst_stop), .len_sel(len_sel),
        .ilv_mode(ilv_mode), .wr_single(wr_single), .col_out(col_out),
        .col_valid(col_valid), .last_beat(last_beat), .cfg_err(cfg_err)
    );

    function automatic int exp_addr();
        if (m_page != 0) return (m_base + m_beat) % 256;
        if (m_ilv != 0)  return m_base ^ m_beat;
        return m_base - (m_base % m_len) + ((m_base % m_len) + m_beat) % m_len;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_err = 0; m_beat = 0;
        end else if (cmd_start) begin
            int len;
            int bad;
            bad = 0; len = 1;
            case (len_sel)
                3'b000: len = 1;
                3'b001: len = 2;
                3'b010: len = 4;
                3'b011: len = 8;
                3'b111: begin len = 256; bad = ilv_mode; end
                default: bad = 1;
            endcase
            if (bad != 0) begin
                m_act = 0; m_err = 1;
            end else begin
                if (wr_single && cmd_write) len = 1;
                m_act = 1; m_err = 0; m_base = cmd_col; m_beat = 0;
                m_page = (len == 256) ? 1 : 0; m_len = len; m_ilv = ilv_mode;
            end
        end else begin
            m_err = 0;
            if (burst_stop) m_act = 0;
            else if (m_act != 0) begin
                if (m_page == 0 && m_beat == m_len - 1) m_act = 0;
                else m_beat = (m_beat + 1) % 256;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            int e_valid, e_last, e_col;
            e_valid = m_act;
            e_last  = (m_act != 0 && m_page == 0 && m_beat == m_len - 1) ? 1 : 0;
            e_col   = exp_addr();
            n_chk++;
            if (col_valid !== e_valid[0] || last_beat !== e_last[0] || cfg_err !== m_err[0] ||
                (e_valid != 0 && col_out !== e_col[7:0])) begin
                n_bad++;
                $display("FAIL %s cycle %0d: valid/last/err/col actual %b/%b/%b/%0d expected %0d/%0d/%0d/%0d",
                         cur_req, cyc, col_valid, last_beat, cfg_err, col_out,
                         e_valid, e_last, m_err, e_col);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // caller sits on a falling edge; leaves on the next falling edge
    task automatic issue(input logic wr, input int col, input logic [2:0] ls,
                         input logic il, input logic sw, input logic st);
        cmd_start = 1'b1; cmd_write = wr; cmd_col = col[7:0];
        len_sel = ls; ilv_mode = il; wr_single = sw; burst_stop = st;
        @(negedge clk);
        cmd_start = 1'b0; burst_stop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_now();
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
    endtask

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R4";
        issue(0, 5, 3'b011, 0, 0, 0); idle(10);
        issue(0, 6, 3'b010, 0, 0, 0); idle(6);
        cur_req = "R3";
        issue(0, 3, 3'b001, 0, 0, 0); idle(4);
        issue(1, 9, 3'b000, 0, 0, 0); idle(3);
        cur_req = "R2";
        issue(0, 8'hF3, 3'b011, 0, 0, 0); idle(10);

        cur_req = "R5";
        issue(0, 5, 3'b011, 1, 0, 0); idle(10);
        issue(0, 2, 3'b010, 1, 0, 0); idle(6);
        issue(0, 8'hAB, 3'b001, 1, 0, 0); idle(4);

        cur_req = "R6";
        issue(0, 250, 3'b111, 0, 0, 0); idle(300);
        cur_req = "R9";
        stop_now(); idle(5);
        issue(0, 0, 3'b011, 0, 0, 0); idle(3);
        stop_now(); idle(6);

        cur_req = "R7";
        issue(0, 12, 3'b010, 0, 0, 0); idle(3);
        issue(0, 40, 3'b010, 1, 0, 0); idle(6);

        cur_req = "R10";
        issue(0, 4, 3'b011, 0, 0, 0); idle(2);
        issue(0, 17, 3'b010, 1, 0, 0); idle(1);
        issue(0, 100, 3'b011, 0, 0, 1); idle(10);
        issue(0, 60, 3'b111, 0, 0, 0); idle(5);
        issue(0, 30, 3'b001, 0, 0, 0); idle(4);

        cur_req = "R8";
        issue(0, 7, 3'b111, 1, 0, 0); idle(3);
        issue(0, 7, 3'b101, 0, 0, 0); idle(3);
        issue(0, 1, 3'b011, 0, 0, 0); idle(2);
        issue(0, 9, 3'b100, 0, 0, 0); idle(4);
        issue(0, 1, 3'b111, 0, 0, 0); idle(2);
        issue(0, 9, 3'b110, 1, 0, 0); idle(4);

        cur_req = "R11";
        issue(1, 21, 3'b011, 0, 1, 0); idle(4);
        issue(0, 21, 3'b011, 0, 1, 0); idle(10);
        issue(1, 21, 3'b011, 0, 0, 0); idle(10);
        issue(1, 33, 3'b111, 0, 1, 0); idle(4);
        issue(1, 33, 3'b111, 1, 1, 0); idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule